// File: doc/BRIEF.md
# Mixed-Sign Widened Multiplier

This block multiplies two operands in one clock. Each operand carries its own signedness flag, so a single multiply array handles signed by signed, unsigned by unsigned, and either mixed pairing. Before the multiply, each operand is widened by one bit. A signed operand gets its top bit copied into the new bit. An unsigned operand gets a zero. The array therefore always works on signed values that are one bit wider than the operands, and every combination of signedness gives the exact product.

A format flag selects integer or fractional (1.15) interpretation. In fractional mode the raw product is doubled, which places the binary point of a 1.15 by 1.15 product at 1.31. Because the array is one bit wider than the operands, the corner case minus one times minus one comes out as exactly plus one. The doubled product is then sign-extended to the accumulator width.

The result is captured in a register on a strobe, and an output valid flag follows the strobe by one cycle. Between strobes the result register holds its value. Accumulation, rounding and saturation are left to the datapath downstream.

Top module: `mixsign_mul`

## Requirements
- R1: After reset, `res_vld` is 0 and `res` is all zeros.
- R2: `res_vld` is 1 in the cycle after a cycle in which `go` was 1, and 0 in the cycle after a cycle in which `go` was 0.
- R3: In a cycle where `go` is 0, `res` keeps its previous value whatever the operand, signedness and format inputs do.
- R4: With `a_sgn`=1 and `b_sgn`=1, both operands are taken as two's complement and the integer product is exact; for example, 0x8000 times 0x8000 gives 0x0040000000.
- R5: An operand whose signedness bit is 0 is taken as an unsigned value; for example, 0xFFFF times 0xFFFF, both unsigned, gives 0x00FFFE0001.
- R6: Mixed signedness is exact; for example, 0xFFFF signed (that is, -1) times 0xFFFF unsigned gives -65535, which is 0xFFFFFF0001.
- R7: With `frac`=1, `res` is twice the integer product, so bit 0 of `res` is 0.
- R8: In fractional mode, 0x8000 times 0x8000 with both operands signed gives exactly +1.0 in 1.31 alignment, which is 0x0080000000, with no wrap.
- R9: `res` is the two's complement product sign-extended to ACC_W bits; the bits above the product field all equal the product's sign bit.
- R10: An unsigned-by-unsigned product is never negative; bit ACC_W-1 of `res` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Strobe; captures the product of the present inputs |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| a_sgn | input | 1 | 1: op_a is signed; 0: op_a is unsigned |
| b_sgn | input | 1 | 1: op_b is signed; 0: op_b is unsigned |
| frac | input | 1 | 1: fractional format (product doubled); 0: integer |
| res_vld | output | 1 | Result valid, one cycle after go |
| res | output | ACC_W | Sign-extended product |

## Verification
A 4-bit instance is swept exhaustively over every operand pair, all four signedness pairings and both formats. Operands with the top bit set are what separate sign extension from zero extension, and the fractional sweep shows whether the doubling and the resulting sign are right. At the default width, directed corners run first: the most negative value squared, all-ones values under each pairing, and zero. A pseudo-random sweep follows, to catch faults in the wider array that the small instance cannot reach. Holds without a strobe are interleaved to show that the result register stays unchanged and the valid flag drops.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
   typedef enum logic {FMT_INT = 1'b0, FMT_FRAC = 1'b1} fmt_e;
   typedef enum int {ARCH_DIRECT = 0, ARCH_SHIFTADD = 1} arch_e;
endpackage

// File: rtl/mixmul_opext.sv
module mixmul_opext #(
   parameter int W = 16
) (
   input  logic [W-1:0]      op,
   input  logic              sgn,
   output logic signed [W:0] ext
);
   always_comb ext = {sgn & op[W-1], op};
endmodule

// File: rtl/mixmul_core.sv
module mixmul_core
   import mixmul_pkg::*;
#(
   parameter int    M    = 17,
   parameter arch_e ARCH = ARCH_DIRECT,
   localparam int   PW   = 2*M
) (
   input  logic signed [M-1:0]  a,
   input  logic signed [M-1:0]  b,
   output logic signed [PW-1:0] p
);
   logic signed [PW-1:0] ax, bx;
   always_comb begin
      ax = {{M{a[M-1]}}, a};
      bx = {{M{b[M-1]}}, b};
   end

   generate
      if (ARCH == ARCH_DIRECT) begin : g_direct
         always_comb p = ax * bx;
      end else begin : g_shiftadd
         always_comb begin
            logic signed [PW-1:0] acc;
            acc = '0;
            for (int i = 0; i < M-1; i++) begin
               if (b[i]) acc = acc + (ax <<< i);
            end
            if (b[M-1]) acc = acc - (ax <<< (M-1));
            p = acc;
         end
      end
   endgenerate
endmodule

// File: rtl/mixmul_align.sv
module mixmul_align #(
   parameter int  PW    = 34,
   parameter int  ACC_W = 40,
   localparam int SW    = PW + 1
) (
   input  logic signed [PW-1:0] p,
   input  logic                 frac,
   output logic [ACC_W-1:0]     r
);
   logic [SW-1:0] sh;
   always_comb begin
      sh = frac ? {p, 1'b0} : {p[PW-1], p};
      r  = {{(ACC_W-SW){sh[SW-1]}}, sh};
   end
endmodule

// File: rtl/mixsign_mul.sv
module mixsign_mul
   import mixmul_pkg::*;
#(
   parameter int    OP_W  = 16,
   parameter int    ACC_W = 40,
   parameter arch_e ARCH  = ARCH_DIRECT,
   localparam int   M     = OP_W + 1,
   localparam int   PW    = 2*M
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic             a_sgn,
   input  logic             b_sgn,
   input  logic             frac,
   output logic             res_vld,
   output logic [ACC_W-1:0] res
);
   generate
      if (OP_W < 2) begin : g_bad_w
         $error("mixsign_mul: OP_W must be at least 2");
      end
      if (ACC_W < PW + 2) begin : g_bad_acc
         $error("mixsign_mul: ACC_W must be at least 2*OP_W+4");
      end
   endgenerate

   logic [OP_W-1:0]      ops [2];
   logic                 sgns[2];
   logic signed [M-1:0]  wide[2];
   logic signed [PW-1:0] prod;
   logic [ACC_W-1:0]     aligned;

   always_comb begin
      ops[0]  = op_a;
      ops[1]  = op_b;
      sgns[0] = a_sgn;
      sgns[1] = b_sgn;
   end

   for (genvar k = 0; k < 2; k++) begin : g_ext
      mixmul_opext #(.W(OP_W)) u_ext (
         .op  (ops[k]),
         .sgn (sgns[k]),
         .ext (wide[k])
      );
   end

   mixmul_core #(.M(M), .ARCH(ARCH)) u_core (
      .a (wide[0]),
      .b (wide[1]),
      .p (prod)
   );

   mixmul_align #(.PW(PW), .ACC_W(ACC_W)) u_align (
      .p    (prod),
      .frac (frac),
      .r    (aligned)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res     <= '0;
      end else begin
         res_vld <= go;
         if (go) res <= aligned;
      end
   end
endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [OP_W-1:0]  op_a,
   input logic [OP_W-1:0]  op_b,
   input logic             a_sgn,
   input logic             b_sgn,
   input logic             frac,
   input logic             res_vld,
   input logic [ACC_W-1:0] res
);
   localparam int TOPLO = 2*OP_W + 2;
   localparam int TOPN  = ACC_W - TOPLO;

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> res_vld);
   // R2
   vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !res_vld);
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(res));
   // R7
   frac_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && frac) |=> !res[0]);
   // R10
   unsigned_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !a_sgn && !b_sgn) |=> !res[ACC_W-1]);
   // R4
   zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && (op_a == '0 || op_b == '0)) |=> (res == '0));
   // R9
   sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> ($countones(res[ACC_W-1:TOPLO]) == 0 ||
                   $countones(res[ACC_W-1:TOPLO]) == TOPN));
endmodule

bind mixsign_mul mixmul_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .op_a(op_a), .op_b(op_b),
   .a_sgn(a_sgn), .b_sgn(b_sgn), .frac(frac), .res_vld(res_vld), .res(res)
);

// File: tb/sim_mixsign_mul.sv
`timescale 1ns/1ps
module sim_mixsign_mul;
   localparam int BW = 16, BA = 40;
   localparam int SW = 4,  SA = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          b_go = 0, b_as = 0, b_bs = 0, b_fr = 0, b_vld;
   logic [BW-1:0] b_a = '0, b_b = '0;
   logic [BA-1:0] b_res;
   logic          s_go = 0, s_as = 0, s_bs = 0, s_fr = 0, s_vld;
   logic [SW-1:0] s_a = '0, s_b = '0;
   logic [SA-1:0] s_res;

   mixsign_mul #(.OP_W(BW), .ACC_W(BA)) u0 (
      .clk(clk), .rst_n(rst_n), .go(b_go), .op_a(b_a), .op_b(b_b),
      .a_sgn(b_as), .b_sgn(b_bs), .frac(b_fr), .res_vld(b_vld), .res(b_res));
   mixsign_mul #(.OP_W(SW), .ACC_W(SA), .ARCH(mixmul_pkg::ARCH_SHIFTADD)) u1 (
      .clk(clk), .rst_n(rst_n), .go(s_go), .op_a(s_a), .op_b(s_b),
      .a_sgn(s_as), .b_sgn(s_bs), .frac(s_fr), .res_vld(s_vld), .res(s_res));

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   function automatic longint model(int w, int aw, longint a, longint b,
                                    bit as, bit bs, bit fr);
      longint ea, eb, p;
      ea = (as && a[w-1]) ? a - (longint'(1) <<< w) : a;
      eb = (bs && b[w-1]) ? b - (longint'(1) <<< w) : b;
      p  = ea * eb;
      if (fr) p = p * 2;
      return p & ((longint'(1) <<< aw) - 1);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic string req_of(bit as, bit bs, bit fr);
      if (fr)            return "R7";
      if (as && bs)      return "R4";
      if (!as && !bs)    return "R5";
      return "R6";
   endfunction

   task automatic big(logic [BW-1:0] a, logic [BW-1:0] b, bit as, bit bs, bit fr, string req);
      @(negedge clk);
      b_a = a; b_b = b; b_as = as; b_bs = bs; b_fr = fr; b_go = 1;
      @(negedge clk);
      b_go = 0;
      chk("R2 valid", longint'(b_vld), 1);
      chk(req, longint'(b_res), model(BW, BA, longint'(a), longint'(b), as, bs, fr));
   endtask

   task automatic big_hold();
      logic [BA-1:0] prev;
      prev = b_res;
      b_a = ~b_a; b_b = b_b + 16'h1234; b_as = ~b_as; b_fr = ~b_fr; b_go = 0;
      @(negedge clk);
      chk("R3 hold", longint'(b_res), longint'(prev));
      chk("R2 drop", longint'(b_vld), 0);
   endtask

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      chk("R1 vld", longint'(b_vld), 0);
      chk("R1 res", longint'(b_res), 0);
      chk("R1 small", longint'(s_res), 0);
      rst_n = 1;
      @(negedge clk);

      big(16'h8000, 16'h8000, 1, 1, 0, "R4");
      chk("R4 value", longint'(b_res), 64'h0040000000);
      big(16'hFFFF, 16'hFFFF, 0, 0, 0, "R5");
      chk("R5 value", longint'(b_res), 64'h00FFFE0001);
      big_hold();
      big(16'hFFFF, 16'hFFFF, 1, 0, 0, "R6");
      chk("R6 value", longint'(b_res), 64'hFFFFFF0001);
      big(16'hFFFF, 16'hFFFF, 0, 1, 0, "R6");
      big(16'h8000, 16'h8000, 1, 1, 1, "R8");
      chk("R8 value", longint'(b_res), 64'h0080000000);
      big(16'h7FFF, 16'h8000, 1, 1, 1, "R9");
      chk("R9 top", longint'(b_res[BA-1:34]), 64'h3F);
      big(16'h0000, 16'hABCD, 1, 1, 0, "R4");
      big(16'hFFFF, 16'hFFFF, 0, 0, 1, "R10");
      chk("R10 sign", longint'(b_res[BA-1]), 0);
      big_hold();

      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 600; i++) begin
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         big(lfsr[31:16], lfsr[15:0], lfsr[3], lfsr[9], lfsr[5],
             req_of(lfsr[3], lfsr[9], lfsr[5]));
         if (i % 50 == 0) big_hold();
      end

      for (int fr = 0; fr < 2; fr++)
         for (int sg = 0; sg < 4; sg++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++) begin
                  @(negedge clk);
                  s_a = SW'(a); s_b = SW'(b); s_as = sg[0]; s_bs = sg[1];
                  s_fr = fr[0]; s_go = 1;
                  @(negedge clk);
                  s_go = 0;
                  chk("R2 small", longint'(s_vld), 1);
                  chk(req_of(sg[0], sg[1], fr[0]), longint'(s_res),
                      model(SW, SA, longint'(a), longint'(b), sg[0], sg[1], fr[0]));
               end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule